// File: doc/BRIEF.md
# Nested Hardware Loop Controller

This block gives a simple instruction sequencer loops with no branch overhead. A loop command carries a 32-bit iteration count and the address of the last word of the loop body. The first address fetched after the command becomes the loop start. The block compares every fetch address with the current loop end. On a match it either tells the fetch unit to jump back to the start in the same cycle, or it lets the fetch continue in sequence when the last pass is done.

Each loop command first saves the current loop context on an internal stack: the counter, the end address, the start address and the active flag. Loops can therefore nest. When a loop finishes, or is cut short by an early-exit command, the saved context is restored and the enclosing loop goes on where it was. The remaining count can be read at any time. Sticky flags report a stack overflow and a stack underflow.

Top module: `hwloop_ctrl`

## Requirements
- R1: After reset, loop_active_o, redirect_o, overflow_o and underflow_o are 0 and count_o is 0.
- R2: A loop command (do_valid_i=1 with enddo_i=0) makes loop_active_o=1 and count_o=do_count_i from the next cycle on.
- R3: The loop start is the fetch_addr_i of the first cycle with fetch_valid_i=1 after the loop command, that cycle included. Every repeat drives this address on redirect_addr_o.
- R4: While loop_active_o=1, a fetch of the loop end address with count_o greater than 1 raises redirect_o in that same cycle, and count_o drops by one in the next cycle.
- R5: A fetch of the loop end address with count_o of 1 (or 0) leaves redirect_o low. In the next cycle the saved outer context is restored: count, end address, start address and loop_active_o.
- R6: enddo_i=1 restores the saved context in the same way as a normal exit, whatever is being fetched. A loop command in the same cycle is ignored.
- R7: No end-of-loop check happens while loop_active_o=0, or in a cycle that carries a loop command or enddo_i.
- R8: A loop whose body is one word (start address equal to end address) runs exactly count passes. It raises redirect_o count-1 times.
- R9: Loops nest up to DEPTH levels. A loop command when the stack is full sets overflow_o, which then stays set. The new loop is still loaded, but the context it replaces is lost.
- R10: An exit when the stack is empty sets underflow_o, which then stays set, and loads the reset context: loop inactive, count 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| do_valid_i | input | 1 | Loop command strobe |
| do_count_i | input | 32 | Iteration count for the loop command |
| do_end_addr_i | input | 16 | Address of the last word of the loop body |
| enddo_i | input | 1 | Early-exit command for the current loop |
| fetch_valid_i | input | 1 | A fetch happens this cycle |
| fetch_addr_i | input | 16 | Address fetched this cycle |
| redirect_o | output | 1 | Next fetch must go to redirect_addr_o |
| redirect_addr_o | output | 16 | Loop start address |
| loop_active_o | output | 1 | A loop is in progress |
| count_o | output | 32 | Current loop counter |
| overflow_o | output | 1 | Sticky flag: push on a full stack |
| underflow_o | output | 1 | Sticky flag: pop on an empty stack |

## Verification
The assertions assume that a loop command and an early exit are single-cycle strobes, and that the fetch unit follows redirect_o on its next fetch. They make no assumption about how loops are nested. The random stimulus models a sequencer whose program counter goes either to the redirect address or to the next address. It places each loop end a few words ahead of the start and keeps counts between 1 and 4, so that loops really finish. Loop commands and early exits land at random points, so overflow, underflow and the same-cycle conflicts are reached both at random and by directed steps.

// File: rtl/hwloop_pkg.sv
package hwloop_pkg;
  localparam int unsigned ADDR_W = 16;
  localparam int unsigned CNT_W  = 32;

  typedef struct packed {
    logic              lf;    // loop active
    logic              pend;  // start address not captured yet
    logic [ADDR_W-1:0] ls;    // loop start
    logic [ADDR_W-1:0] la;    // loop end
    logic [CNT_W-1:0]  lc;    // loop counter
  } loop_ctx_t;

  localparam loop_ctx_t CTX_RESET = '0;
endpackage

// File: rtl/hwloop_stack.sv
module hwloop_stack
  import hwloop_pkg::*;
#(
  parameter int unsigned DEPTH = 4
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      push_i,
  input  logic      pop_i,
  input  loop_ctx_t push_ctx_i,
  output loop_ctx_t top_ctx_o,
  output logic      ovf_o,
  output logic      udf_o
);
  localparam int unsigned SP_W = $clog2(DEPTH + 1);

  loop_ctx_t       mem_q [DEPTH];
  logic [SP_W-1:0] sp_q;
  logic            full, empty;
  logic            ovf_q, udf_q;

  assign full  = (sp_q == SP_W'(DEPTH));
  assign empty = (sp_q == '0);

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mem_q[i] <= CTX_RESET;
      else if (push_i && !pop_i && sp_q == SP_W'(i)) mem_q[i] <= push_ctx_i;
    end
  end

  always_comb begin
    top_ctx_o = CTX_RESET;
    for (int i = 0; i < DEPTH; i++)
      if (sp_q == SP_W'(i + 1)) top_ctx_o = mem_q[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sp_q  <= '0;
      ovf_q <= 1'b0;
      udf_q <= 1'b0;
    end else if (pop_i) begin
      if (empty) udf_q <= 1'b1;
      else       sp_q  <= sp_q - 1'b1;
    end else if (push_i) begin
      if (full) ovf_q <= 1'b1;
      else      sp_q  <= sp_q + 1'b1;
    end
  end

  assign ovf_o = ovf_q;
  assign udf_o = udf_q;

  AST_SP_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sp_q <= SP_W'(DEPTH)); // R9
  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> ovf_o); // R9
  AST_UDF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    udf_o |=> udf_o); // R10
endmodule

// File: rtl/hwloop_match.sv
module hwloop_match
  import hwloop_pkg::*;
(
  input  logic              active_i,
  input  logic              cmd_i,
  input  logic              fetch_valid_i,
  input  logic [ADDR_W-1:0] fetch_addr_i,
  input  logic [ADDR_W-1:0] end_addr_i,
  input  logic [CNT_W-1:0]  count_i,
  output logic              hit_o,
  output logic              last_o
);
  assign hit_o  = active_i && !cmd_i && fetch_valid_i && (fetch_addr_i == end_addr_i);
  assign last_o = (count_i <= CNT_W'(1));
endmodule

// File: rtl/hwloop_ctrl.sv
module hwloop_ctrl
  import hwloop_pkg::*;
#(
  parameter int unsigned DEPTH = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              do_valid_i,
  input  logic [CNT_W-1:0]  do_count_i,
  input  logic [ADDR_W-1:0] do_end_addr_i,
  input  logic              enddo_i,
  input  logic              fetch_valid_i,
  input  logic [ADDR_W-1:0] fetch_addr_i,
  output logic              redirect_o,
  output logic [ADDR_W-1:0] redirect_addr_o,
  output logic              loop_active_o,
  output logic [CNT_W-1:0]  count_o,
  output logic              overflow_o,
  output logic              underflow_o
);
  loop_ctx_t ctx_q, ctx_d, top_ctx;
  logic      do_cmd, hit, last, exit_loop, repeat_loop;

  assign do_cmd = do_valid_i && !enddo_i;

  hwloop_match u_match (
    .active_i      (ctx_q.lf),
    .cmd_i         (do_valid_i || enddo_i),
    .fetch_valid_i (fetch_valid_i),
    .fetch_addr_i  (fetch_addr_i),
    .end_addr_i    (ctx_q.la),
    .count_i       (ctx_q.lc),
    .hit_o         (hit),
    .last_o        (last)
  );

  assign exit_loop   = enddo_i || (hit && last);
  assign repeat_loop = hit && !last;

  hwloop_stack #(.DEPTH(DEPTH)) u_stack (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (do_cmd),
    .pop_i      (exit_loop),
    .push_ctx_i (ctx_q),
    .top_ctx_o  (top_ctx),
    .ovf_o      (overflow_o),
    .udf_o      (underflow_o)
  );

  always_comb begin
    ctx_d = ctx_q;
    if (exit_loop) begin
      ctx_d = top_ctx;
    end else if (do_cmd) begin
      ctx_d.lf   = 1'b1;
      ctx_d.pend = 1'b1;
      ctx_d.ls   = '0;
      ctx_d.la   = do_end_addr_i;
      ctx_d.lc   = do_count_i;
    end else begin
      if (repeat_loop) ctx_d.lc = ctx_q.lc - 1'b1;
      if (fetch_valid_i && ctx_q.pend) begin
        ctx_d.ls   = fetch_addr_i;
        ctx_d.pend = 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctx_q <= CTX_RESET;
    else         ctx_q <= ctx_d;
  end

  // start not yet captured: the current fetch is the start
  assign redirect_o      = repeat_loop;
  assign redirect_addr_o = ctx_q.pend ? fetch_addr_i : ctx_q.ls;
  assign loop_active_o   = ctx_q.lf;
  assign count_o         = ctx_q.lc;

  AST_REDIRECT_ACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_o |-> loop_active_o); // R4
  AST_REPEAT_DEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_o |=> count_o == $past(count_o) - 1'b1); // R4
  AST_DO_LOADS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (do_valid_i && !enddo_i) |=> (loop_active_o && count_o == $past(do_count_i))); // R2
  AST_IDLE_NO_REDIRECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (do_valid_i || enddo_i || !loop_active_o) |-> !redirect_o); // R7
endmodule

// File: tb/hwloop_ctrl_tb.sv
`timescale 1ns/1ps
module hwloop_ctrl_tb;
  localparam int DEPTH = 4;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        do_valid_i = 1'b0;
  logic [31:0] do_count_i = '0;
  logic [15:0] do_end_addr_i = '0;
  logic        enddo_i = 1'b0;
  logic        fetch_valid_i = 1'b0;
  logic [15:0] fetch_addr_i = '0;
  logic        redirect_o;
  logic [15:0] redirect_addr_o;
  logic        loop_active_o;
  logic [31:0] count_o;
  logic        overflow_o, underflow_o;

  always #4 clk_i = ~clk_i;

  hwloop_ctrl #(.DEPTH(DEPTH)) u_dut (.*);

  int checks = 0, errors = 0;
  bit done = 0;

  // reference state
  logic        m_lf, m_pend, m_ovf, m_udf;
  logic [15:0] m_ls, m_la;
  logic [31:0] m_lc;
  int          m_sp;
  logic        s_lf[DEPTH], s_pend[DEPTH];
  logic [15:0] s_ls[DEPTH], s_la[DEPTH];
  logic [31:0] s_lc[DEPTH];
  logic        last_redir;
  logic [15:0] last_raddr;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_lf = 0; m_pend = 0; m_ovf = 0; m_udf = 0;
    m_ls = '0; m_la = '0; m_lc = '0; m_sp = 0;
  endtask

  function automatic logic exp_hit(input logic d, input logic en, input logic fv, input logic [15:0] fa);
    return m_lf && !d && !en && fv && (fa == m_la);
  endfunction

  task automatic step(input logic d, input logic [31:0] c, input logic [15:0] e,
                      input logic en, input logic fv, input logic [15:0] fa);
    logic hit, rep;
    @(negedge clk_i);
    do_valid_i = d; do_count_i = c; do_end_addr_i = e;
    enddo_i = en; fetch_valid_i = fv; fetch_addr_i = fa;
    #1;
    hit = exp_hit(d, en, fv, fa);
    rep = hit && (m_lc > 1);
    check("R5 loop_active_o", 32'(loop_active_o), 32'(m_lf));
    check("R2 count_o", count_o, m_lc);
    check("R9 overflow_o", 32'(overflow_o), 32'(m_ovf));
    check("R10 underflow_o", 32'(underflow_o), 32'(m_udf));
    check("R4 redirect_o", 32'(redirect_o), 32'(rep));
    if (rep) check("R3 redirect_addr_o", 32'(redirect_addr_o), 32'(m_pend ? fa : m_ls));
    last_redir = redirect_o;
    last_raddr = redirect_addr_o;
    @(posedge clk_i);
    if (en || (hit && m_lc <= 1)) begin
      if (m_sp == 0) begin
        m_udf = 1; m_lf = 0; m_pend = 0; m_ls = '0; m_la = '0; m_lc = '0;
      end else begin
        m_sp--;
        m_lf = s_lf[m_sp]; m_pend = s_pend[m_sp]; m_ls = s_ls[m_sp];
        m_la = s_la[m_sp]; m_lc = s_lc[m_sp];
      end
    end else if (d) begin
      if (m_sp == DEPTH) m_ovf = 1;
      else begin
        s_lf[m_sp] = m_lf; s_pend[m_sp] = m_pend; s_ls[m_sp] = m_ls;
        s_la[m_sp] = m_la; s_lc[m_sp] = m_lc; m_sp++;
      end
      m_lf = 1; m_pend = 1; m_ls = '0; m_la = e; m_lc = c;
    end else begin
      if (rep) m_lc = m_lc - 1;
      if (fv && m_pend) begin m_ls = fa; m_pend = 0; end
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 0;
    do_valid_i = 0; enddo_i = 0; fetch_valid_i = 0;
    model_reset();
    @(negedge clk_i);
    rst_ni = 1;
  endtask

  initial begin
    #(8ns * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int reds;
    logic [15:0] pc;
    void'($urandom(32'd4242));
    model_reset();
    do_reset();
    #1;
    // R1 reset state
    check("R1 loop_active_o", 32'(loop_active_o), 0);
    check("R1 count_o", count_o, 0);
    check("R1 redirect_o", 32'(redirect_o), 0);
    check("R1 flags", 32'({overflow_o, underflow_o}), 0);

    // R8 single-word body, count 3
    step(1, 3, 16'h0100, 0, 0, 0);
    reds = 0;
    for (int k = 0; k < 3; k++) begin
      step(0, 0, 0, 0, 1, 16'h0100);
      if (last_redir) begin
        reds++;
        check("R8 redirect target", 32'(last_raddr), 32'h0100);
      end
    end
    check("R8 redirect count", reds, 2);
    step(0, 0, 0, 0, 0, 0);
    check("R8 loop done", 32'(loop_active_o), 0);

    // R5/R3 nested: outer start 0x10 end 0x14, inner end 0x12
    do_reset();
    step(1, 2, 16'h0014, 0, 0, 0);
    step(0, 0, 0, 0, 1, 16'h0010);
    step(1, 2, 16'h0012, 0, 0, 0);
    step(0, 0, 0, 0, 1, 16'h0011);
    step(0, 0, 0, 0, 1, 16'h0012);
    check("R3 inner start", 32'(last_raddr), 32'h0011);
    step(0, 0, 0, 0, 1, 16'h0011);
    step(0, 0, 0, 0, 1, 16'h0012);
    check("R5 inner exit no redirect", 32'(last_redir), 0);
    step(0, 0, 0, 0, 0, 0);
    check("R5 outer count restored", count_o, 2);
    step(0, 0, 0, 0, 1, 16'h0014);
    check("R3 outer start", 32'(last_raddr), 32'h0010);

    // R7: end fetch with a loop command in the same cycle is not checked
    step(0, 0, 0, 0, 0, 0);
    step(1, 7, 16'h0014, 0, 1, 16'h0014);
    check("R7 no redirect with command", 32'(last_redir), 0);
    // R6: early exit wins over a loop command
    step(1, 9, 16'h0030, 1, 0, 0);
    step(0, 0, 0, 0, 0, 0);
    check("R6 enddo over do count", count_o, 1);
    check("R6 enddo over do active", 32'(loop_active_o), 1);

    // R9 overflow then R10 underflow
    do_reset();
    for (int k = 0; k < DEPTH + 1; k++) step(1, 32'(k + 5), 16'h0200, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0);
    check("R9 overflow set", 32'(overflow_o), 1);
    check("R9 newest loaded", count_o, 32'(DEPTH + 5));
    for (int k = 0; k < DEPTH + 1; k++) step(0, 0, 0, 1, 0, 0);
    step(0, 0, 0, 0, 0, 0);
    check("R10 underflow set", 32'(underflow_o), 1);
    check("R10 reset context", 32'(loop_active_o), 0);

    // random sequencer
    do_reset();
    pc = 16'h0400;
    for (int n = 0; n < 4000; n++) begin
      int r;
      r = int'($urandom % 100);
      if (r < 6)
        step(1, 32'($urandom % 4 + 1), pc + 16'($urandom % 4), 0, 0, 0);
      else if (r < 8)
        step(0, 0, 0, 1, 0, 0);
      else if (r < 80) begin
        step(0, 0, 0, 0, 1, pc);
        pc = last_redir ? last_raddr : pc + 1'b1;
      end else
        step(0, 0, 0, 0, 0, 0);
      if (n % 500 == 499) begin
        do_reset();
        pc = 16'h0400;
      end
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule